// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits on the synchronous side of a chip and turns single-word read and write requests into the strobe sequence an external asynchronous static RAM needs. The RAM has 17 address bits, 8 data bits, one active-low and one active-high chip select, an active-low output enable and an active-low write enable. Every timing limit of the selected speed grade is a nanosecond parameter. Each limit is converted to a count of system clocks by rounding up, and a down-counter holds each phase for that many clocks.

A requester offers a request while `req_ready` is high. The controller latches the address, the direction and the write data, then runs one access. A read keeps the RAM selected with output enable low for the read window and samples the data bus on the last clock of that window. The controller then releases the bus and waits out the turnaround time. A write keeps the RAM selected with write enable low and drives the data bus only during that pulse, then waits out the rest of the write cycle. Each access ends with a one-clock `rsp_valid` pulse. On a read, the captured byte is on `rsp_rdata` during that pulse. The data bus is split into an output word, an input word and an output-enable, and the pad ring builds the tristate buffer from these three signals.

The state machine has five states:
- IDLE: ready, with every strobe inactive.
- RD_ACCESS: read window.
- RD_TURN: output released, waiting for the bus to turn around.
- WR_PULSE: write enable low, data driven.
- WR_RECOV: deselected, filling out the write cycle.

It has six transitions:
- IDLE→RD_ACCESS: a read request is accepted.
- IDLE→WR_PULSE: a write request is accepted.
- RD_ACCESS→RD_TURN: the read window expires, and the data is captured.
- RD_TURN→IDLE: the turnaround count expires.
- WR_PULSE→WR_RECOV: the pulse count expires.
- WR_RECOV→IDLE: the recovery count expires.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle has `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0, and `req_ready`=1 once reset is released.
- R2: `req_ready` is 1 only in IDLE, where all strobes are inactive. A request (`req_valid`=1) is taken only at an edge where `req_ready` is 1. Request inputs that change while `req_ready` is 0 have no effect on the access in progress.
- R3: A read keeps the RAM selected (`mem_cs_n`=0, `mem_cs`=1) with `mem_oe_n`=0 and `mem_we_n`=1 for exactly NRD cycles, starting the cycle after acceptance. NRD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_OE/CLK), which is 7 with the defaults. `mem_addr` equals the accepted address and stays stable throughout.
- R4: Read data is sampled from `mem_dq_in` on the last clock of the read window. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the cycle right after the window.
- R5: After a read, the RAM is deselected with `mem_oe_n`=1 for NHZ=ceil(T_HZ/CLK) cycles (3 with the defaults) before `req_ready` returns. Write enable never goes low earlier than NHZ cycles after output enable went high.
- R6: A write keeps the RAM selected with `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 for exactly NWR cycles, with `mem_dq_out` equal to the accepted data. NWR is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK), ceil(T_CW/CLK) and ceil(T_DW/CLK), which is 7 with the defaults. `mem_dq_oe` is 1 only while write enable is low and the RAM is selected.
- R7: After the write pulse, the RAM is deselected for NWREC cycles, where NWREC = max(ceil(T_WC/CLK) − NWR, 1), which is 1 with the defaults. `rsp_valid` is 1 in the first of these cycles, and then `req_ready` returns.
- R8: Output enable and write enable are never low in the same cycle, and the controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | RAM address bus |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | 8 | Data returned from the RAM |

## Verification
The assertions check on every clock that:
- output enable and write enable never overlap;
- the bus is driven only inside a selected write pulse;
- each write pulse lasts at least NWR clocks;
- write enable respects the turnaround gap after output enable;
- the address holds while the RAM is selected;
- `rsp_valid` follows directly on an access;
- reset quiets all strobes.

Only the bench scenarios can show the rest:
- the exact phase lengths;
- that the read byte is sampled on the last window clock and no earlier, which depends on a RAM model that returns valid data late;
- that data written to the lowest and highest addresses reads back;
- that request inputs changed during a busy access are ignored;
- that a reset in mid-read leaves the controller idle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctrl_state_e;

    // Nanoseconds to whole clocks, rounding up.
    function automatic int unsigned cycles_for(int unsigned t_ns, int unsigned clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (cap_en)
            rdata_q <= mem_dq_in;
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 55,
    parameter int T_AW_NS       = 65,
    parameter int T_CW_NS       = 65,
    parameter int T_DW_NS       = 30,
    parameter int T_HZ_NS       = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned CK     = CLK_PERIOD_NS;
    localparam int unsigned N_RD   = max2(max2(cycles_for(T_RC_NS, CK), cycles_for(T_AA_NS, CK)),
                                          max2(cycles_for(T_OE_NS, CK), 1));
    localparam int unsigned N_WR   = max2(max2(cycles_for(T_WP_NS, CK), cycles_for(T_AW_NS, CK)),
                                          max2(max2(cycles_for(T_CW_NS, CK), cycles_for(T_DW_NS, CK)), 1));
    localparam int unsigned N_WC   = cycles_for(T_WC_NS, CK);
    localparam int unsigned N_WREC = (N_WC > N_WR + 1) ? (N_WC - N_WR) : 1;
    localparam int unsigned N_HZ   = max2(cycles_for(T_HZ_NS, CK), 1);
    localparam int unsigned N_MAX  = max2(max2(N_RD, N_WR), max2(N_WREC, N_HZ));
    localparam int          CNT_W  = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(N_WR - 1);
    localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(N_WREC - 1);
    localparam logic [CNT_W-1:0] LD_HZ   = CNT_W'(N_HZ - 1);

    ctrl_state_e      st, st_nxt;
    logic             tmr_load, tmr_expired, accept, cap_en, sel, done_q;
    logic [CNT_W-1:0] tmr_val;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_en    (cap_en),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= cap_en || ((st == ST_WR_PULSE) && tmr_expired);
        end
    end

    // Transitions and timer loads
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        cap_en   = 1'b0;
        unique case (st)
            ST_IDLE: if (req_valid) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                if (req_write) begin
                    st_nxt  = ST_WR_PULSE;
                    tmr_val = LD_WR;
                end else begin
                    st_nxt  = ST_RD_ACCESS;
                    tmr_val = LD_RD;
                end
            end
            ST_RD_ACCESS: if (tmr_expired) begin
                cap_en   = 1'b1;
                st_nxt   = ST_RD_TURN;
                tmr_load = 1'b1;
                tmr_val  = LD_HZ;
            end
            ST_RD_TURN: if (tmr_expired) st_nxt = ST_IDLE;
            ST_WR_PULSE: if (tmr_expired) begin
                st_nxt   = ST_WR_RECOV;
                tmr_load = 1'b1;
                tmr_val  = LD_WREC;
            end
            ST_WR_RECOV: if (tmr_expired) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Strobe outputs
    always_comb begin
        sel       = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (st)
            ST_IDLE:      req_ready = 1'b1;
            ST_RD_ACCESS: begin sel = 1'b1; mem_oe_n = 1'b0; end
            ST_WR_PULSE:  begin sel = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_RD_TURN, ST_WR_RECOV: ;
            default: ;
        endcase
    end

    assign mem_cs_n  = !sel;
    assign mem_cs    = sel;
    assign rsp_valid = done_q;

    // Checker state: length of the current write pulse, and cycles since output enable went high
    logic [CNT_W-1:0] we_low_cnt, oe_hi_cnt;
    localparam logic [CNT_W-1:0] NWR_V = CNT_W'(N_WR);
    localparam logic [CNT_W-1:0] NHZ_V = CNT_W'(N_HZ);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_hi_cnt  <= NHZ_V;
        end else begin
            we_low_cnt <= !mem_we_n ? ((we_low_cnt == NWR_V) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
            oe_hi_cnt  <= !mem_oe_n ? '0 : ((oe_hi_cnt >= NHZ_V) ? oe_hi_cnt : oe_hi_cnt + 1'b1);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    a_r4_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n || !mem_we_n) && mem_cs_n));
    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> (oe_hi_cnt >= NHZ_V));
    a_r6_dq_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_cs));
    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= NWR_V));
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && (!mem_we_n || mem_dq_oe)));
endmodule

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;
    localparam int CLK_NS = 10;
    localparam int AW = 17;
    localparam int DW = 8;

    function automatic int up(int t); return (t + CLK_NS - 1) / CLK_NS; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction
    localparam int NRD   = mx(mx(up(70), up(70)), up(35));
    localparam int NWR   = mx(mx(up(55), up(65)), mx(up(65), up(30)));
    localparam int NWREC = (up(70) - NWR > 1) ? up(70) - NWR : 1;
    localparam int NHZ   = up(25);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int errors = 0, checks = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_strobe_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u0 (.*);

    // RAM model: data becomes valid only on the last cycle of the read window
    logic [DW-1:0] ram [int];
    int oe_cycles = 0;
    function automatic logic [DW-1:0] dflt(int a); return DW'(a) ^ 8'h3C; endfunction
    function automatic logic [DW-1:0] ram_rd(int a);
        return ram.exists(a) ? ram[a] : dflt(a);
    endfunction
    always @(posedge clk) oe_cycles <= (!mem_cs_n && !mem_oe_n) ? oe_cycles + 1 : 0;
    always @* mem_dq_in = (!mem_cs_n && mem_cs && !mem_oe_n && oe_cycles >= NRD - 1)
                          ? ram_rd(int'(mem_addr)) : 8'hA5;

    typedef struct {
        logic sel, oe_n, we_n, dq_oe, rdy, rv;
        int tag;
    } exp_t;
    exp_t q[$];
    logic [DW-1:0] shadow [int];
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata, cur_rexp;
    logic cur_rd;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tname(int t); return $sformatf("R%0d", t); endfunction

    // Cycle-by-cycle reference model
    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else begin
            exp_t e;
            bit was_idle;
            was_idle = (q.size() == 0);
            if (was_idle) e = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2};
            else e = q.pop_front();
            chk(mem_cs_n == !e.sel && mem_cs == e.sel, tname(e.tag), "select", {mem_cs_n, mem_cs}, {!e.sel, e.sel});
            chk(mem_oe_n == e.oe_n, tname(e.tag), "oe_n", mem_oe_n, e.oe_n);
            chk(mem_we_n == e.we_n, tname(e.tag), "we_n", mem_we_n, e.we_n);
            chk(mem_dq_oe == e.dq_oe, tname(e.tag), "dq_oe", mem_dq_oe, e.dq_oe);
            chk(req_ready == e.rdy, "R2", "ready", req_ready, e.rdy);
            chk(rsp_valid == e.rv, e.rv ? "R4" : tname(e.tag), "rsp_valid", rsp_valid, e.rv);
            // R8: no overlap of enables, no drive while output enabled
            chk(!(!mem_oe_n && (!mem_we_n || mem_dq_oe)), "R8", "overlap", {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
            if (e.sel)
                chk(mem_addr == cur_addr, tname(e.tag), "addr", int'(mem_addr), int'(cur_addr));
            if (e.dq_oe) begin
                chk(mem_dq_out == cur_wdata, "R6", "wdata", mem_dq_out, cur_wdata);
                ram[int'(mem_addr)] = mem_dq_out;
            end
            if (e.rv && cur_rd)
                chk(rsp_rdata == cur_rexp, "R4", "rdata", rsp_rdata, cur_rexp);
            if (was_idle && req_valid) begin
                cur_addr = req_addr;
                cur_wdata = req_wdata;
                cur_rd = !req_write;
                if (req_write) begin
                    shadow[int'(req_addr)] = req_wdata;
                    for (int i = 0; i < NWR; i++) q.push_back('{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6});
                    for (int i = 0; i < NWREC; i++) q.push_back('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, i == 0, 7});
                end else begin
                    cur_rexp = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : dflt(int'(req_addr));
                    for (int i = 0; i < NRD; i++) q.push_back('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3});
                    for (int i = 0; i < NHZ; i++) q.push_back('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, i == 0, 5});
                end
            end
        end
    end

    // Offer a request and keep it offered until taken; valid stays high afterwards
    task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
    endtask

    task automatic go_idle(int n);
        req_valid = 1'b0;
        req_addr = 17'h0BEEF; req_wdata = 8'h5A; req_write = 1'b1;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "reset state",
            {req_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
        @(posedge clk); #1;
        issue(1'b0, 17'h00010, 8'h00);       // R3 R4: read unwritten word
        go_idle(15);
        issue(1'b1, 17'h1FFFF, 8'hC3);       // R6 R7: write top address
        go_idle(10);
        issue(1'b0, 17'h1FFFF, 8'h00);       // R4: read it back
        go_idle(12);
        issue(1'b1, 17'h00000, 8'hFF);       // lowest address
        issue(1'b0, 17'h00000, 8'h00);       // R2: offered while busy, taken later
        issue(1'b1, 17'h00123, 8'h81);       // R5: write straight after read
        issue(1'b1, 17'h00124, 8'h18);
        issue(1'b0, 17'h00123, 8'h00);
        issue(1'b0, 17'h00124, 8'h00);
        go_idle(15);
        // R1: reset in mid-read
        issue(1'b0, 17'h00124, 8'h00);
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && mem_oe_n && !rsp_valid, "R1", "after mid reset",
            {req_ready, mem_cs_n, mem_oe_n, rsp_valid}, 4'b1110);
        @(posedge clk); #1;
        issue(1'b0, 17'h1FFFF, 8'h00);
        go_idle(15);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule